// File: doc/BRIEF.md
# Soft-Off Exit Watchdog with Clock-Reset Retry

This block sits at one decision point of a platform power sequencer: the soft-off state, where the chipset is expected to release its deep-sleep request. After a trigger, it watches a synchronised copy of the active-low deep-sleep input. If the input goes high in time, it reports that sequencing may go on to the next higher power state.

If the wait expires first, the block recovers instead of raising an error. It emits a force-off pulse and then a real-time-clock reset pulse. It then either reports a retry from full off after a settling interval, or reports that the platform should stay off. A retry counter persists across waits and caps the number of attempts. The counter clears on a successful exit and when the block gives up.

All intervals are counted in clock ticks. The counts are derived from the clock rate in kHz and from millisecond parameters: a 4000 ms wait, 1 ms pulses, a 10 ms settle and five attempts by default. The surrounding sequencer issues the trigger and acts on the reported code.

Top module: `s5_exit_guard`

## Requirements
- R1: While `rst_n` is low, and after it is released, `force_off`, `rtc_rst` and `done` are low and `next_code` is 2'b00 (none).
- R2: The deep-sleep input passes through two flops. If `s4_sleep_n` is high before a rising edge while the block is waiting, `done` rises with `next_code` = 2'b01 (proceed) on the third rising edge from that point.
- R3: If the synchronised input stays low for TIMEOUT_MS*TICK_KHZ cycles of waiting, `force_off` is high for exactly PULSE_MS*TICK_KHZ cycles. It is never high while `done` is high.
- R4: `rtc_rst` is high for exactly PULSE_MS*TICK_KHZ cycles, starting in the cycle after `force_off` falls. The two pulses never overlap.
- R5: After a timeout that is not the final one, SETTLE_MS*TICK_KHZ quiet cycles follow the clock-reset pulse. Then `done` rises with `next_code` = 2'b10 (retry from full off). One attempt therefore takes 1+T+2P+S edges from the trigger.
- R6: On the MAX_TRIES-th consecutive timeout, `done` rises in the cycle right after the clock-reset pulse, with `next_code` = 2'b11 (stay off). There is no settle interval.
- R7: Giving up clears the retry count. The next sequence again needs MAX_TRIES timeouts before it reports stay-off.
- R8: A successful exit clears the retry count. After it, MAX_TRIES further timeouts are needed before stay-off.
- R9: `wait_start` is ignored whenever the block is not idle, so the timing of an attempt in progress is unchanged.
- R10: `done` is high for one cycle only. `next_code` holds its value until the next accepted trigger, which sets it to 2'b00 on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s4_sleep_n | input | 1 | Deep-sleep request from the chipset, active low, asynchronous |
| wait_start | input | 1 | Starts a wait when the block is idle |
| force_off | output | 1 | Force-to-full-off pulse |
| rtc_rst | output | 1 | Real-time-clock reset pulse |
| done | output | 1 | One-cycle strobe: `next_code` is valid |
| next_code | output | 2 | 00 none, 01 proceed, 10 retry from off, 11 stay off |

## Verification
A stale or corrupted retry count is invisible on a single attempt. It shows up only when the stay-off code arrives on the wrong attempt, which can be as many as MAX_TRIES attempts later. For that reason the bench runs full chains of timeouts after both a success and a give-up. A wrong phase or interval count appears within one attempt as a pulse of the wrong length, overlapping pulses, or `done` arriving in the wrong cycle. A per-cycle reference model catches any of these on the first cycle where they differ.

// File: rtl/s5g_pkg.sv
// Shared types for the soft-off exit watchdog.
// Assumes: the result code values are decoded by the surrounding sequencer.
package s5g_pkg;
    typedef enum logic [1:0] {
        NXT_NONE     = 2'b00,
        NXT_PROCEED  = 2'b01,
        NXT_RETRY    = 2'b10,
        NXT_STAY_OFF = 2'b11
    } nxt_code_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT,
        PH_FORCE,
        PH_RTC,
        PH_SETTLE
    } phase_t;
endpackage

// File: rtl/s5g_sync.sv
// Multi-flop synchroniser for a single asynchronous level.
// Assumes: the input is a slow level, so no pulse is narrower than a cycle.
module s5g_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the flop chain; reset to the asserted level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/s5g_interval.sv
// Up-counting interval timer shared by every timed phase.
// Assumes: limit >= 1, and limit stays stable while run is high within a phase.
module s5g_interval #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    assign expire = run && (cnt_q == limit - 1'b1);

    // Count while running; wrap to zero at expiry or when cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (expire)    cnt_q <= '0;
        else if (run)       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/s5g_retry_ctr.sv
// Persistent count of consecutive failed waits.
// Assumes: clear has priority over increment.
module s5g_retry_ctr #(
    parameter int MAX_TRIES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic clr,
    output logic exhausted
);
    localparam int CW = $clog2(MAX_TRIES + 1);
    logic [CW-1:0] cnt_q;

    assign exhausted = (cnt_q == CW'(MAX_TRIES));

    // Bump on each timeout, saturating at the cap; clear on success or give-up.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          cnt_q <= '0;
        else if (inc && !exhausted) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/s5_exit_guard.sv
// Soft-off exit watchdog. It waits for the deep-sleep input to release; on
// timeout it pulses force-off, then a clock reset, and either requests a
// retry from full off or gives up after MAX_TRIES consecutive failures.
// Assumes: all *_MS parameters >= 1, and TICK_KHZ is the clock rate in kHz.
module s5_exit_guard
    import s5g_pkg::*;
#(
    parameter int TICK_KHZ    = 1000,
    parameter int TIMEOUT_MS  = 4000,
    parameter int PULSE_MS    = 1,
    parameter int SETTLE_MS   = 10,
    parameter int MAX_TRIES   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s4_sleep_n,
    input  logic       wait_start,
    output logic       force_off,
    output logic       rtc_rst,
    output logic       done,
    output logic [1:0] next_code
);
    localparam int TIMEOUT_CYC = TICK_KHZ * TIMEOUT_MS;
    localparam int PULSE_CYC   = TICK_KHZ * PULSE_MS;
    localparam int SETTLE_CYC  = TICK_KHZ * SETTLE_MS;
    localparam int LONG_A      = (TIMEOUT_CYC > PULSE_CYC) ? TIMEOUT_CYC : PULSE_CYC;
    localparam int LONGEST     = (LONG_A > SETTLE_CYC) ? LONG_A : SETTLE_CYC;
    localparam int TW          = $clog2(LONGEST + 1);

    logic      s4_released;
    phase_t    phase_q;
    logic [TW-1:0] limit;
    logic      tmr_expire;
    logic      try_inc, try_clr, tries_out;
    logic      done_q;
    nxt_code_t code_q;

    s5g_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (s4_sleep_n),
        .q     (s4_released)
    );

    // Select the length of the phase in progress.
    always_comb begin
        case (phase_q)
            PH_FORCE, PH_RTC: limit = TW'(PULSE_CYC);
            PH_SETTLE:        limit = TW'(SETTLE_CYC);
            default:          limit = TW'(TIMEOUT_CYC);
        endcase
    end

    s5g_interval #(.W(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (phase_q == PH_IDLE),
        .run    (phase_q != PH_IDLE),
        .limit  (limit),
        .expire (tmr_expire)
    );

    // Count a failure at wait expiry; clear on success or at give-up.
    always_comb begin
        try_inc = (phase_q == PH_WAIT) && !s4_released && tmr_expire;
        try_clr = ((phase_q == PH_WAIT) && s4_released) ||
                  ((phase_q == PH_RTC) && tmr_expire && tries_out);
    end

    s5g_retry_ctr #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (try_inc),
        .clr       (try_clr),
        .exhausted (tries_out)
    );

    // Phase sequencing, result code and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            code_q  <= NXT_NONE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (wait_start) begin
                        phase_q <= PH_WAIT;
                        code_q  <= NXT_NONE;
                    end
                end
                PH_WAIT: begin
                    if (s4_released) begin
                        phase_q <= PH_IDLE;
                        code_q  <= NXT_PROCEED;
                        done_q  <= 1'b1;
                    end else if (tmr_expire) begin
                        phase_q <= PH_FORCE;
                    end
                end
                PH_FORCE: begin
                    if (tmr_expire) phase_q <= PH_RTC;
                end
                PH_RTC: begin
                    if (tmr_expire) begin
                        if (tries_out) begin
                            phase_q <= PH_IDLE;
                            code_q  <= NXT_STAY_OFF;
                            done_q  <= 1'b1;
                        end else begin
                            phase_q <= PH_SETTLE;
                        end
                    end
                end
                PH_SETTLE: begin
                    if (tmr_expire) begin
                        phase_q <= PH_IDLE;
                        code_q  <= NXT_RETRY;
                        done_q  <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign force_off = (phase_q == PH_FORCE);
    assign rtc_rst   = (phase_q == PH_RTC);
    assign done      = done_q;
    assign next_code = code_q;
endmodule

// File: rtl/s5_exit_guard_chk.sv
// Port-level protocol checks for the soft-off exit watchdog, bound to the top.
module s5_exit_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wait_start,
    input logic       force_off,
    input logic       rtc_rst,
    input logic       done,
    input logic [1:0] next_code
);
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(force_off && rtc_rst)); // R4
    AST_RTC_FOLLOWS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rtc_rst) |-> $past(force_off)); // R4
    AST_NO_FORCE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !force_off && !rtc_rst); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_start |=> done || $stable(next_code)); // R10
    AST_STAY_OFF_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && next_code == 2'b11) |-> $past(rtc_rst)); // R6
    AST_RETRY_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && next_code == 2'b10) |-> !$past(rtc_rst) && !$past(force_off)); // R5
endmodule

bind s5_exit_guard s5_exit_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wait_start (wait_start),
    .force_off  (force_off),
    .rtc_rst    (rtc_rst),
    .done       (done),
    .next_code  (next_code)
);

// File: tb/s5_exit_guard_test.sv
// Self-checking bench: behavioural per-cycle model plus directed scenarios.
module s5_exit_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int KHZ  = 1;
    localparam int TMS  = 12;
    localparam int PMS  = 2;
    localparam int SMS  = 3;
    localparam int MAXT = 5;
    localparam int T = KHZ * TMS;
    localparam int P = KHZ * PMS;
    localparam int S = KHZ * SMS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s4_sleep_n = 1'b0;
    logic wait_start = 1'b0;
    logic force_off, rtc_rst, done;
    logic [1:0] next_code;

    int errs = 0;
    int checks = 0;

    s5_exit_guard #(
        .TICK_KHZ(KHZ), .TIMEOUT_MS(TMS), .PULSE_MS(PMS),
        .SETTLE_MS(SMS), .MAX_TRIES(MAXT), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .s4_sleep_n(s4_sleep_n), .wait_start(wait_start),
        .force_off(force_off), .rtc_rst(rtc_rst), .done(done), .next_code(next_code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural model: countdown per phase, history queue for the synchroniser.
    bit sync_hist[$] = '{1'b0, 1'b0};
    int m_phase = 0, m_left = 0, m_tries = 0, m_code = 0, m_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            sync_hist = '{1'b0, 1'b0};
            m_phase = 0; m_left = 0; m_tries = 0; m_code = 0; m_done = 0;
        end else begin
            bit seen;
            seen = sync_hist[0];
            void'(sync_hist.pop_front());
            sync_hist.push_back(s4_sleep_n);
            m_done = 0;
            case (m_phase)
                0: if (wait_start) begin m_phase = 1; m_left = T; m_code = 0; end
                1: if (seen) begin m_phase = 0; m_code = 1; m_done = 1; m_tries = 0; end
                   else if (m_left == 1) begin m_phase = 2; m_left = P; m_tries++; end
                   else m_left--;
                2: if (m_left == 1) begin m_phase = 3; m_left = P; end else m_left--;
                3: if (m_left == 1) begin
                       if (m_tries >= MAXT) begin
                           m_phase = 0; m_code = 3; m_done = 1; m_tries = 0;
                       end else begin m_phase = 4; m_left = S; end
                   end else m_left--;
                4: if (m_left == 1) begin m_phase = 0; m_code = 2; m_done = 1; end
                   else m_left--;
                default: m_phase = 0;
            endcase
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(force_off == (m_phase == 2), "R3 model force_off", force_off, m_phase == 2);
            chk(rtc_rst == (m_phase == 3), "R4 model rtc_rst", rtc_rst, m_phase == 3);
            chk(done == m_done[0], "R10 model done", done, m_done);
            chk(next_code == m_code[1:0], "R2 model next_code", next_code, m_code);
        end
    end

    // Run one attempt that times out; poke re-asserts the trigger mid-attempt.
    task automatic timeout_attempt(input int exp_code, input int poke, input string req);
        int cyc, nf, nr, exp_cyc;
        @(negedge clk); wait_start = 1'b1;
        @(negedge clk); wait_start = 1'b0;
        cyc = 1; nf = force_off; nr = rtc_rst;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            wait_start = (cyc == poke);
            nf += force_off; nr += rtc_rst;
        end
        wait_start = 1'b0;
        exp_cyc = (exp_code == 2) ? 1 + T + 2 * P + S : 1 + T + 2 * P;
        chk(next_code == exp_code[1:0], {req, " code"}, next_code, exp_code);
        chk(cyc == exp_cyc, {req, " attempt length"}, cyc, exp_cyc);
        chk(nf == P, "R3 force_off width", nf, P);
        chk(nr == P, "R4 rtc_rst width", nr, P);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!force_off && !rtc_rst && !done, "R1 outputs in reset", {force_off, rtc_rst, done}, 0);
        chk(next_code == 2'b00, "R1 code in reset", next_code, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!force_off && !rtc_rst && !done && next_code == 2'b00, "R1 after release",
            {force_off, rtc_rst, done, next_code}, 0);

        // Two non-final timeouts, the second with a trigger poked during the pulses.
        timeout_attempt(2, 0, "R5 first timeout");
        timeout_attempt(2, T + 3, "R9 trigger while busy");

        // Successful exit: three-edge latency, then the counter must be clear.
        begin
            int c;
            @(negedge clk); wait_start = 1'b1;
            @(negedge clk); wait_start = 1'b0;
            repeat (3) @(negedge clk);
            s4_sleep_n = 1'b1;
            c = 0;
            while (!done && c < 50) begin @(negedge clk); c++; end
            chk(c == 3, "R2 release latency", c, 3);
            chk(next_code == 2'b01, "R2 proceed code", next_code, 1);
            @(negedge clk);
            chk(!done, "R10 done single cycle", done, 0);
            s4_sleep_n = 1'b0;
            repeat (4) @(negedge clk);
            chk(next_code == 2'b01, "R10 code held", next_code, 1);
        end

        // After success the full budget is available again.
        for (int i = 0; i < MAXT - 1; i++) timeout_attempt(2, 0, "R8 retry after success");
        timeout_attempt(3, 0, "R6 final timeout");

        // After giving up the budget restarts.
        for (int i = 0; i < MAXT - 1; i++) timeout_attempt(2, 0, "R7 retry after give-up");
        timeout_attempt(3, 0, "R7 stay-off again");

        // Accepted trigger clears the held code on the next edge.
        repeat (3) @(negedge clk);
        chk(next_code == 2'b11, "R10 code held idle", next_code, 3);
        wait_start = 1'b1;
        @(negedge clk); wait_start = 1'b0;
        chk(next_code == 2'b00, "R10 code cleared by trigger", next_code, 0);
        while (!done) @(negedge clk);
        chk(next_code == 2'b10, "R5 retry after cleared code", next_code, 2);
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule